// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table held in memory. The address uses 4 KB pages, so the low 12 bits are the page offset and go through untouched. The upper 20 bits split into two 10-bit indices. The upper index selects a word in the first-level table, which sits at the page given by the root frame input. When that word is usable, it names the page that holds the second-level table. The lower index then selects the final entry in that table, and the final entry gives the physical frame and its write permission.

A request is taken only while the walker is idle. The walker then makes one word read at a time on a simple memory port. It pulses a request with an address and waits for a read-valid strobe that carries the data. A successful walk makes two reads. If the first-level entry is not usable, the subtree is treated as absent and the walk stops after one read. The result comes back as a one-cycle response that holds either the physical address or a fault with its cause. Software can use a fault to fill the page on demand. A small translation cache can sit in front and pass its misses to this block.

Top module: `pt_walk2`

## Requirements
- R1: Reset state. While reset is applied and just after it is released, the walker shows `req_ready` = 1, `mem_req` = 0 and `rsp_valid` = 0.
- R2: Acceptance. A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. While a walk is in progress, `req_ready` is 0, and any `req_valid` or `req_vaddr` activity has no effect on the reads or on the response.
- R3: First read address. The first read goes to `root_frame`·4096 + `req_vaddr[31:22]`·4.
- R4: Second read address. The second read goes to F1·4096 + `req_vaddr[21:12]`·4, where F1 is bits 31:12 of the first-level entry.
- R5: Entry encoding. Bit 0 is valid and bit 1 is writable. Bits 31:12 hold the frame number. An entry is usable only when bit 0 is 1 and bits 11:2 are all zero. An entry with any nonzero bit in 11:2 counts as invalid.
- R6: First-level fault. If the first-level entry is not usable, the walk ends after exactly one read with `rsp_fault` = 1 and `rsp_cause` = 1.
- R7: Second-level fault. If the second-level entry is not usable, the walk ends after two reads with `rsp_fault` = 1 and `rsp_cause` = 2.
- R8: Write protection. The effective write permission is the AND of the writable bits of both entries. A request with `req_write` = 1 and effective permission 0 ends with `rsp_fault` = 1 and `rsp_cause` = 3.
- R9: Success. A successful walk returns `rsp_fault` = 0, `rsp_cause` = 0 and `rsp_paddr` = {final frame, `req_vaddr[11:0]`}. `rsp_writable` shows the effective write permission.
- R10: Response. `rsp_valid` lasts exactly one cycle, and `req_ready` is 1 in the cycle after it. On any fault, `rsp_paddr` = 0 and `rsp_writable` = 0.
- R11: Memory port. Each `mem_req` pulse lasts one cycle. No new read is issued until `mem_rvalid` has returned the data for the previous one. No read is issued while the walker is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| root_frame | input | 20 | Frame number of the first-level table |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | 32 | Byte address of the word to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_paddr | output | 32 | Translated physical address, zero on fault |
| rsp_writable | output | 1 | Effective write permission |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_cause | output | 2 | 0 none, 1 first-level invalid, 2 second-level invalid, 3 write to read-only page |

## Verification
Some internal faults show up as a wrong address on the memory port. A corrupted stored index or a wrong level select appears in the read address, in the same cycle that `mem_req` rises. A wrong stop decision shows in the read count, which is one read where two were due or two where one was due, and this is seen when the response arrives. A wrong permission merge or a wrong offset register shows only in the response fields, within at most three cycles after the last `mem_rvalid`. The sweep varies memory latency and the table contents, so that every cause and every path through the walk appears.

// File: rtl/pt_walk2_pkg.sv
package pt_walk2_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD1  = 3'd1,
    ST_WT1  = 3'd2,
    ST_RD2  = 3'd3,
    ST_WT2  = 3'd4,
    ST_DONE = 3'd5
  } walk_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_L1   = 2'd1,
    CAUSE_L2   = 2'd2,
    CAUSE_WP   = 2'd3
  } walk_cause_e;
endpackage

// File: rtl/pt_walk2_decode.sv
module pt_walk2_decode #(
  parameter int PTE_W   = 32,
  parameter int FRAME_W = 20
) (
  input  logic [PTE_W-1:0]   entry,
  output logic               usable,
  output logic               writable,
  output logic [FRAME_W-1:0] frame
);
  localparam int RSV_HI = PTE_W - FRAME_W - 1;

  always_comb begin
    usable   = entry[0] && (entry[RSV_HI:2] == '0);
    writable = entry[1];
    frame    = entry[PTE_W-1 -: FRAME_W];
  end
endmodule

// File: rtl/pt_walk2_addr.sv
module pt_walk2_addr #(
  parameter int ADDR_W  = 32,
  parameter int FRAME_W = 20,
  parameter int IDX_W   = 10
) (
  input  logic               sel_l2,
  input  logic [FRAME_W-1:0] root_frame,
  input  logic [FRAME_W-1:0] l1_frame,
  input  logic [IDX_W-1:0]   idx1,
  input  logic [IDX_W-1:0]   idx2,
  output logic [ADDR_W-1:0]  addr
);
  localparam int OFFS_W = ADDR_W - FRAME_W;

  logic [FRAME_W-1:0] base;
  logic [IDX_W-1:0]   idx;

  always_comb begin
    base = sel_l2 ? l1_frame : root_frame;
    idx  = sel_l2 ? idx2 : idx1;
    addr = {base, {OFFS_W{1'b0}}} + ADDR_W'({idx, 2'b00});
  end
endmodule

// File: rtl/pt_walk2.sv
module pt_walk2 #(
  parameter int ADDR_W      = 32,
  parameter int PAGE_OFFS_W = 12,
  parameter int PTE_W       = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [ADDR_W-1:0]             req_vaddr,
  input  logic                          req_write,
  input  logic [ADDR_W-PAGE_OFFS_W-1:0] root_frame,
  output logic                          mem_req,
  output logic [ADDR_W-1:0]             mem_addr,
  input  logic                          mem_rvalid,
  input  logic [PTE_W-1:0]              mem_rdata,
  output logic                          rsp_valid,
  output logic [ADDR_W-1:0]             rsp_paddr,
  output logic                          rsp_writable,
  output logic                          rsp_fault,
  output logic [1:0]                    rsp_cause
);
  import pt_walk2_pkg::*;

  localparam int FRAME_W = ADDR_W - PAGE_OFFS_W;
  localparam int IDX_W   = FRAME_W / 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  walk_state_e state_q, state_d;
  logic [ADDR_W-1:0]  vaddr_q;
  logic               wr_q;
  logic [FRAME_W-1:0] root_q;
  logic [FRAME_W-1:0] l1_frame_q;
  logic               l1_wr_q;
  logic [FRAME_W-1:0] frame_q;
  logic               res_wr_q;
  logic               fault_q;
  logic [1:0]         cause_q;

  logic               ld_req, ld_l1, ld_res;
  logic [FRAME_W-1:0] res_frame_d;
  logic               res_wr_d, res_fault_d;
  walk_cause_e        res_cause_d;
  logic               eff_wr;

  logic               dec_ok, dec_wr;
  logic [FRAME_W-1:0] dec_frame;

  pt_walk2_decode #(.PTE_W(PTE_W), .FRAME_W(FRAME_W)) u_dec (
    .entry   (mem_rdata),
    .usable  (dec_ok),
    .writable(dec_wr),
    .frame   (dec_frame)
  );

  pt_walk2_addr #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_addr (
    .sel_l2    (state_q == ST_RD2),
    .root_frame(root_q),
    .l1_frame  (l1_frame_q),
    .idx1      (vaddr_q[ADDR_W-1 -: IDX_W]),
    .idx2      (vaddr_q[ADDR_W-1-IDX_W -: IDX_W]),
    .addr      (mem_addr)
  );

  // next-state logic
  always_comb begin
    state_d     = state_q;
    ld_req      = 1'b0;
    ld_l1       = 1'b0;
    ld_res      = 1'b0;
    res_frame_d = '0;
    res_wr_d    = 1'b0;
    res_fault_d = 1'b0;
    res_cause_d = CAUSE_NONE;
    eff_wr      = l1_wr_q & dec_wr;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        ld_req  = 1'b1;
        state_d = ST_RD1;
      end
      ST_RD1: state_d = ST_WT1;
      ST_WT1: if (mem_rvalid) begin
        if (!dec_ok) begin
          ld_res      = 1'b1;
          res_fault_d = 1'b1;
          res_cause_d = CAUSE_L1;
          state_d     = ST_DONE;
        end else begin
          ld_l1   = 1'b1;
          state_d = ST_RD2;
        end
      end
      ST_RD2: state_d = ST_WT2;
      ST_WT2: if (mem_rvalid) begin
        ld_res  = 1'b1;
        state_d = ST_DONE;
        if (!dec_ok) begin
          res_fault_d = 1'b1;
          res_cause_d = CAUSE_L2;
        end else if (wr_q && !eff_wr) begin
          res_fault_d = 1'b1;
          res_cause_d = CAUSE_WP;
        end else begin
          res_frame_d = dec_frame;
          res_wr_d    = eff_wr;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q    <= ST_IDLE;
      vaddr_q    <= '0;
      wr_q       <= 1'b0;
      root_q     <= '0;
      l1_frame_q <= '0;
      l1_wr_q    <= 1'b0;
      frame_q    <= '0;
      res_wr_q   <= 1'b0;
      fault_q    <= 1'b0;
      cause_q    <= 2'd0;
    end else begin
      state_q <= state_d;
      if (ld_req) begin
        vaddr_q <= req_vaddr;
        wr_q    <= req_write;
        root_q  <= root_frame;
      end
      if (ld_l1) begin
        l1_frame_q <= dec_frame;
        l1_wr_q    <= dec_wr;
      end
      if (ld_res) begin
        frame_q  <= res_frame_d;
        res_wr_q <= res_wr_d;
        fault_q  <= res_fault_d;
        cause_q  <= res_cause_d;
      end
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign mem_req      = (state_q == ST_RD1) || (state_q == ST_RD2);
  assign rsp_valid    = (state_q == ST_DONE);
  assign rsp_paddr    = fault_q ? '0 : {frame_q, vaddr_q[PAGE_OFFS_W-1:0]};
  assign rsp_writable = res_wr_q;
  assign rsp_fault    = fault_q;
  assign rsp_cause    = cause_q;
endmodule

// File: rtl/pt_walk2_chk.sv
module pt_walk2_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic              rsp_writable,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [1:0]        rsp_cause
);
  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R10
  rsp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);
  // R10
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_writable));
  // R9
  ok_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_cause == 2'd0));
  // R11
  mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  // R11
  idle_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind pt_walk2 pt_walk2_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .mem_req     (mem_req),
  .rsp_valid   (rsp_valid),
  .rsp_fault   (rsp_fault),
  .rsp_writable(rsp_writable),
  .rsp_paddr   (rsp_paddr),
  .rsp_cause   (rsp_cause)
);

// File: tb/sim_pt_walk2.sv
`timescale 1ns/1ps
module sim_pt_walk2;
  localparam logic [19:0] ROOT = 20'h00100;
  localparam logic [19:0] L2B  = 20'h00200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [19:0] root_frame = ROOT;
  logic mem_req, req_ready, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic rsp_valid, rsp_writable, rsp_fault;
  logic [31:0] rsp_paddr;
  logic [1:0] rsp_cause;

  always #4 clk = ~clk;

  pt_walk2 u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .root_frame(root_frame),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_writable(rsp_writable),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause));

  int n_chk = 0, n_bad = 0;
  int latency = 0;
  int rd_n = 0;
  logic [31:0] rd_addr [2];
  logic pend = 1'b0;
  logic [31:0] pend_addr;
  int pend_cnt = 0;
  int cyc = 0;
  bit done = 1'b0;

  function automatic logic [31:0] l1_entry(int i);
    logic [19:0] f = L2B + 20'(i);
    if (i % 3 == 0) return {f, 10'h000, 2'b10};
    if (i % 7 == 5) return {f, 10'h008, 2'b11};
    return {f, 10'h000, (i % 4 != 1), 1'b1};
  endfunction

  function automatic logic [31:0] l2_entry(int t, int j);
    logic [19:0] f = 20'((t * 37 + j * 5 + 3) & 32'hFFFFF);
    if ((t + j) % 5 == 0) return {f, 10'h000, 2'b10};
    if (j % 11 == 10) return {f, 10'h080, 2'b11};
    return {f, 10'h000, j[0], 1'b1};
  endfunction

  function automatic logic [31:0] mem_fn(logic [31:0] a);
    logic [19:0] f = a[31:12];
    int idx = int'(a[11:2]);
    if (f == ROOT) return l1_entry(idx);
    if (f >= L2B && f < L2B + 20'd1024) return l2_entry(int'(f - L2B), idx);
    return 32'hDEAD_BEEF;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (pend) begin
      if (pend_cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem_fn(pend_addr);
        pend = 1'b0;
      end else pend_cnt--;
    end
    if (mem_req) begin
      if (rd_n < 2) rd_addr[rd_n] = mem_addr;
      rd_n++;
      pend = 1'b1;
      pend_addr = mem_addr;
      pend_cnt = latency;
    end
  end

  // global watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic walk(logic [31:0] va, bit wr, bit noise);
    int i = int'(va[31:22]);
    int j = int'(va[21:12]);
    logic [31:0] e1 = l1_entry(i), e2;
    bit ok1 = e1[0] && e1[11:2] == 0, ok2, eff;
    int exp_n;
    logic exp_fault, exp_wr;
    logic [1:0] exp_cause;
    logic [31:0] exp_pa, a0, a1;
    int wd;
    a0 = {ROOT, 12'h000} + {20'h0, va[31:22], 2'b00};
    a1 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
    exp_wr = 1'b0; exp_pa = '0; exp_fault = 1'b1;
    if (!ok1) begin exp_n = 1; exp_cause = 2'd1; end
    else begin
      exp_n = 2;
      e2 = l2_entry(int'(e1[31:12] - L2B), j);
      ok2 = e2[0] && e2[11:2] == 0;
      eff = e1[1] & e2[1];
      if (!ok2) exp_cause = 2'd2;
      else if (wr && !eff) exp_cause = 2'd3;
      else begin
        exp_cause = 2'd0; exp_fault = 1'b0; exp_wr = eff;
        exp_pa = {e2[31:12], va[11:0]};
      end
    end
    rd_n = 0;
    req_vaddr = va; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    if (noise) begin req_vaddr = ~va; req_write = ~wr; end
    else req_valid = 1'b0;
    wd = 0;
    while (!rsp_valid && wd < 60) begin @(negedge clk); wd++; end
    req_valid = 1'b0;
    chk(wd < 60, "R11 walk timeout", 32'(wd), 32'd60);
    chk(rd_n == exp_n, exp_n == 1 ? "R6 read count" : "R7 read count", 32'(rd_n), 32'(exp_n));
    chk(rd_addr[0] == a0, "R3 first address", rd_addr[0], a0);
    if (exp_n == 2 && rd_n >= 2) chk(rd_addr[1] == a1, "R4 second address", rd_addr[1], a1);
    chk(rsp_fault == exp_fault && rsp_cause == exp_cause,
        exp_cause == 2'd3 ? "R8 cause" : (exp_cause == 2'd0 ? "R9 cause" : "R5 R6 R7 cause"),
        {rsp_fault, 29'h0, rsp_cause}, {exp_fault, 29'h0, exp_cause});
    chk(rsp_paddr == exp_pa, "R9 R10 paddr", rsp_paddr, exp_pa);
    chk(rsp_writable == exp_wr, "R8 R9 writable", 32'(rsp_writable), 32'(exp_wr));
    if (noise) chk(1'b1, "R2 busy requests ignored", 0, 0);
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R10 ready after response", {rsp_valid, req_ready}, 32'h1);
    chk(rd_n == exp_n, "R2 no extra read", 32'(rd_n), 32'(exp_n));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req && !rsp_valid, "R1 during reset",
        {mem_req, rsp_valid, req_ready}, 32'h1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req && !rsp_valid, "R1 after reset",
        {mem_req, rsp_valid, req_ready}, 32'h1);
    for (int i = 0; i < 48; i++) begin
      for (int k = 0; k < 6; k++) begin
        for (int w = 0; w < 2; w++) begin
          int jl [6] = '{0, 1, 2, 10, 21, 1023};
          logic [31:0] va;
          va = {10'(i), 10'(jl[k]), 12'((i * 131 + k * 17 + w * 999) & 12'hFFF)};
          latency = (i + k + w) % 3;
          walk(va, w[0], (i + k) % 2 == 1);
        end
      end
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule